// File: doc/BRIEF.md
# UART Receiver with Standby Wakeup

This block is an asynchronous serial receiver meant for a node on a shared multidrop line. It oversamples the selected input by a factor of 16, takes a three-sample majority vote near the middle of each bit, and assembles frames of eight or nine data bits. Data is sent least significant bit first and ends with one stop bit. A received frame is placed in a data register and raises a data-ready flag. A read strobe clears that flag.

Software can put the receiver into standby with a one-cycle strobe. In standby, frames meant for other nodes are thrown away: the data register, the data-ready flag and the framing-error flag all stay untouched. The receiver leaves standby through one of two selectable events. The first is a full character time of idle line. The second is a frame whose top data bit is 1, which marks it as an address frame. An idle flag reports a quiet line while the receiver is awake.

In single-wire mode the receiver samples the shared transmit/receive pin instead of the dedicated receive pin. This lets one pin carry traffic in both directions.

Top module: `uart_rx_standby`

## Requirements
- R1: While reset is low, `rx_data` reads 0, and `data_ready`, `idle_flag`, `frame_err` and `asleep` are all low.
- R2: With `os_tick` high, each bit lasts 16 ticks and is decided by a majority of three samples near mid-bit, so a single-tick glitch does not corrupt it. An 8-bit frame is one low start bit, then data LSB first, then one stop bit. It appears on `rx_data[7:0]`, with `rx_data[8]` = 0, and sets `data_ready`. A `rd_strobe` clears `data_ready` and `frame_err`.
- R3: With `nine_bit` = 1, frames carry nine data bits, LSB first, and all nine appear on `rx_data[8:0]`.
- R4: With `one_wire` = 1 the receiver samples `shared_pin`, and `rx_pin` has no effect. With `one_wire` = 0 it samples `rx_pin`, and `shared_pin` has no effect.
- R5: A stop bit sampled low sets `frame_err` together with `data_ready`, and the frame is still delivered.
- R6: A `sleep_set` strobe makes `asleep` read 1 on the next cycle. While asleep, a frame that does not wake the receiver changes neither `rx_data`, `data_ready` nor `frame_err`.
- R7: With `wake_sel` = 0, a line held high for one character time clears `asleep`. A character time is (data bits + 2) × 16 ticks, counted from the stop-bit decision or from the last low sample. This waking idle stretch sets neither `idle_flag` nor `data_ready`.
- R8: While awake, a line idle for one character time sets `idle_flag` once per idle stretch. `rd_strobe` clears it, and it stays low until the line has been active and then idle again.
- R9: With `wake_sel` = 1, an idle line does not wake the receiver. The address frame clears `asleep` before its stop bit is sampled and is then delivered as data. A frame is an address frame when its most significant data bit (bit 7, or bit 8 when `nine_bit` = 1) is 1. A frame whose top bit is 0 is ignored.
- R10: With `wake_sel` = 0, if `sleep_set` is pulsed while the line has already been idle for a character time, `asleep` returns to 0 on the following cycle.
- R11: A low stop bit on the waking address frame sets `frame_err`. A low stop bit on an ignored frame does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rx_pin | input | 1 | Dedicated serial receive input |
| shared_pin | input | 1 | Sensed level of the shared transmit/receive pin |
| one_wire | input | 1 | 1 = receive from `shared_pin` |
| nine_bit | input | 1 | 1 = nine data bits, 0 = eight |
| wake_sel | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| sleep_set | input | 1 | One-cycle strobe that enters standby |
| rd_strobe | input | 1 | Clears `data_ready`, `frame_err` and `idle_flag` |
| rx_data | output | 9 | Last delivered frame |
| data_ready | output | 1 | New frame available |
| idle_flag | output | 1 | Line idle for a character time while awake |
| frame_err | output | 1 | Delivered frame had a low stop bit |
| asleep | output | 1 | Receiver is in standby |

## Verification
A standby bit that clears too early or too late shows up within one frame. An ignored frame then raises `data_ready` or overwrites `rx_data`, or an address frame is lost, and the bench reads this right after the stop bit. A wrong idle counter shows as `asleep` dropping before, or well after, one character time. A bad bit counter or vote window shows as wrong data bits on the next frame. The address-wake timing is checked at the start of the stop bit, where `asleep` must already be low while `data_ready` is still low.

// File: rtl/rxs_pkg.sv
// Shared types for the standby-capable serial receiver.
package rxs_pkg;
    // Frame engine phases.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } rx_phase_t;
endpackage

// File: rtl/rxs_line_front.sv
// Picks the receive source (dedicated or shared pin) and brings it into the
// clock domain through two flops. Assumes the line idles high.
module rxs_line_front (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic shared_pin,
    input  logic one_wire,
    output logic line_q
);
    logic sel_line;
    logic meta_q;

    // Source selection.
    always_comb sel_line = one_wire ? shared_pin : rx_pin;

    // Two-stage synchronizer, reset to idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            line_q <= 1'b1;
        end else begin
            meta_q <= sel_line;
            line_q <= meta_q;
        end
    end
endmodule

// File: rtl/rxs_frame_engine.sv
// Oversampled frame assembler: start detection, three-sample majority near
// mid-bit, LSB-first data of DMAX-1 or DMAX bits, one stop bit. Reports the
// last data bit as soon as it is decided, ahead of the stop bit.
// Assumes OSR is a power of two and at least 4.
module rxs_frame_engine
    import rxs_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            line,
    input  logic            nine_bit,
    output logic            busy,
    output logic            frame_done,
    output logic            stop_ok,
    output logic [DMAX-1:0] frame_data,
    output logic            last_done,
    output logic            last_val
);
    localparam int CW  = $clog2(OSR);
    localparam int IW  = $clog2(DMAX);
    localparam int MID = OSR / 2;
    localparam logic [CW-1:0] V0   = CW'(MID - 1);
    localparam logic [CW-1:0] V1   = CW'(MID);
    localparam logic [CW-1:0] VDEC = CW'(MID + 1);
    localparam logic [CW-1:0] CEND = CW'(OSR - 1);

    rx_phase_t     phase;
    logic [CW-1:0] cnt;
    logic [IW-1:0] bidx;
    logic [IW-1:0] last_idx;
    logic [1:0]    vote;
    logic          maj;

    // Index of the final data bit for the selected length.
    always_comb last_idx = nine_bit ? IW'(DMAX - 1) : IW'(DMAX - 2);

    // Majority of two stored samples and the current one.
    always_comb maj = (vote[1] & vote[0]) | (vote[1] & line) | (vote[0] & line);

    always_comb busy = (phase != PH_IDLE);

    // Bit timing, sampling and frame assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            bidx       <= '0;
            vote       <= 2'b11;
            frame_data <= '0;
            frame_done <= 1'b0;
            stop_ok    <= 1'b0;
            last_done  <= 1'b0;
            last_val   <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            last_done  <= 1'b0;
            if (tick) begin
                if (phase == PH_IDLE) begin
                    if (!line) begin
                        phase      <= PH_START;
                        cnt        <= '0;
                        frame_data <= '0;
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                    if (cnt == V0 || cnt == V1) begin
                        vote <= {vote[0], line};
                    end
                    if (cnt == VDEC) begin
                        case (phase)
                            PH_START: if (maj) phase <= PH_IDLE;
                            PH_DATA: begin
                                frame_data[bidx] <= maj;
                                if (bidx == last_idx) begin
                                    last_done <= 1'b1;
                                    last_val  <= maj;
                                end
                            end
                            PH_STOP: begin
                                frame_done <= 1'b1;
                                stop_ok    <= maj;
                                phase      <= PH_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt == CEND) begin
                        cnt <= '0;
                        if (phase == PH_START) begin
                            phase <= PH_DATA;
                            bidx  <= '0;
                        end else if (phase == PH_DATA) begin
                            if (bidx == last_idx) phase <= PH_STOP;
                            else                  bidx  <= bidx + IW'(1);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rxs_idle_timer.sv
// Counts ticks of high line while no frame is in progress. Reports a level
// once a full character time has passed, and a one-cycle rise of it.
module rxs_idle_timer #(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic busy,
    input  logic frame_done,
    input  logic nine_bit,
    output logic idle_level,
    output logic idle_rise
);
    localparam int TW = $clog2((DMAX + 2) * OSR + 1);
    localparam logic [TW-1:0] LEN_LONG  = TW'((DMAX + 2) * OSR);
    localparam logic [TW-1:0] LEN_SHORT = TW'((DMAX + 1) * OSR);

    logic [TW-1:0] run;
    logic [TW-1:0] char_len;
    logic          level_q;

    always_comb char_len   = nine_bit ? LEN_LONG : LEN_SHORT;
    always_comb idle_level = (run >= char_len);
    always_comb idle_rise  = idle_level & ~level_q;

    // Idle run counter, restarted by any activity or a finished frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (!line || busy || frame_done) begin
            run <= '0;
        end else if (tick && run < char_len) begin
            run <= run + TW'(1);
        end
    end

    // Previous idle level for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= idle_level;
    end
endmodule

// File: rtl/rxs_standby_ctrl.sv
// Holds the standby bit and the user-visible flags and data register.
// Frames finish delivery only when the receiver is awake at frame end, so an
// address frame that cleared standby earlier in the frame is delivered.
module rxs_standby_ctrl #(
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_set,
    input  logic            wake_sel,
    input  logic            rd_strobe,
    input  logic            idle_level,
    input  logic            idle_rise,
    input  logic            last_done,
    input  logic            last_val,
    input  logic            frame_done,
    input  logic            stop_ok,
    input  logic [DMAX-1:0] frame_data,
    output logic            addr_hit,
    output logic            asleep,
    output logic [DMAX-1:0] rx_data,
    output logic            data_ready,
    output logic            frame_err,
    output logic            idle_flag
);
    logic wake_now;

    // Address frame recognised once its top data bit is decided.
    always_comb addr_hit = wake_sel & last_done & last_val;
    // Wake event for the selected method.
    always_comb wake_now = wake_sel ? addr_hit : idle_level;

    // Standby bit: the set strobe takes priority over a wake event.
    always_ff @(posedge clk) begin
        if (!rst_n)                 asleep <= 1'b0;
        else if (sleep_set)         asleep <= 1'b1;
        else if (asleep && wake_now) asleep <= 1'b0;
    end

    // Data register, ready and framing flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            frame_err  <= 1'b0;
        end else if (frame_done && !asleep) begin
            rx_data    <= frame_data;
            data_ready <= 1'b1;
            frame_err  <= ~stop_ok;
        end else if (rd_strobe) begin
            data_ready <= 1'b0;
            frame_err  <= 1'b0;
        end
    end

    // Idle flag, never raised by the stretch seen during standby.
    always_ff @(posedge clk) begin
        if (!rst_n)                   idle_flag <= 1'b0;
        else if (idle_rise && !asleep) idle_flag <= 1'b1;
        else if (rd_strobe)            idle_flag <= 1'b0;
    end
endmodule

// File: rtl/uart_rx_standby.sv
// Serial receiver with standby for multidrop lines. Wires the line front end,
// frame engine, idle timer and standby control. Assumes os_tick runs at 16x
// (OSR x) the bit rate and the line idles high.
module uart_rx_standby #(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            os_tick,
    input  logic            rx_pin,
    input  logic            shared_pin,
    input  logic            one_wire,
    input  logic            nine_bit,
    input  logic            wake_sel,
    input  logic            sleep_set,
    input  logic            rd_strobe,
    output logic [DMAX-1:0] rx_data,
    output logic            data_ready,
    output logic            idle_flag,
    output logic            frame_err,
    output logic            asleep
);
    logic            line_q;
    logic            busy;
    logic            frame_done;
    logic            stop_ok;
    logic [DMAX-1:0] frame_data;
    logic            last_done;
    logic            last_val;
    logic            idle_level;
    logic            idle_rise;
    logic            addr_hit;

    rxs_line_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_pin     (rx_pin),
        .shared_pin (shared_pin),
        .one_wire   (one_wire),
        .line_q     (line_q)
    );

    rxs_frame_engine #(.OSR(OSR), .DMAX(DMAX)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line       (line_q),
        .nine_bit   (nine_bit),
        .busy       (busy),
        .frame_done (frame_done),
        .stop_ok    (stop_ok),
        .frame_data (frame_data),
        .last_done  (last_done),
        .last_val   (last_val)
    );

    rxs_idle_timer #(.OSR(OSR), .DMAX(DMAX)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line       (line_q),
        .busy       (busy),
        .frame_done (frame_done),
        .nine_bit   (nine_bit),
        .idle_level (idle_level),
        .idle_rise  (idle_rise)
    );

    rxs_standby_ctrl #(.DMAX(DMAX)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_set  (sleep_set),
        .wake_sel   (wake_sel),
        .rd_strobe  (rd_strobe),
        .idle_level (idle_level),
        .idle_rise  (idle_rise),
        .last_done  (last_done),
        .last_val   (last_val),
        .frame_done (frame_done),
        .stop_ok    (stop_ok),
        .frame_data (frame_data),
        .addr_hit   (addr_hit),
        .asleep     (asleep),
        .rx_data    (rx_data),
        .data_ready (data_ready),
        .frame_err  (frame_err),
        .idle_flag  (idle_flag)
    );
endmodule

// File: rtl/rxs_checker.sv
// Temporal checks on the standby receiver, bound to every instance of the top.
module rxs_checker #(
    parameter int DMAX = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wake_sel,
    input logic            sleep_set,
    input logic            rd_strobe,
    input logic [DMAX-1:0] rx_data,
    input logic            data_ready,
    input logic            idle_flag,
    input logic            frame_err,
    input logic            asleep,
    input logic            addr_hit,
    input logic            idle_level,
    input logic            frame_done
);
    AST_SLEEP_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_set |=> asleep); // R6
    AST_DATA_HELD_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> $stable(rx_data)); // R6
    AST_READY_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> !$past(asleep)); // R6
    AST_IDLE_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(asleep) && !$past(wake_sel)) |-> $past(idle_level)); // R7
    AST_NO_IDLE_FLAG_FROM_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(asleep) |-> !$rose(idle_flag)); // R7
    AST_ADDR_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(asleep) && $past(wake_sel)) |-> $past(addr_hit)); // R9
    AST_ERR_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> data_ready); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> (!data_ready && !frame_err)); // R2
endmodule

bind uart_rx_standby rxs_checker #(.DMAX(DMAX)) i_rxs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_sel   (wake_sel),
    .sleep_set  (sleep_set),
    .rd_strobe  (rd_strobe),
    .rx_data    (rx_data),
    .data_ready (data_ready),
    .idle_flag  (idle_flag),
    .frame_err  (frame_err),
    .asleep     (asleep),
    .addr_hit   (addr_hit),
    .idle_level (idle_level),
    .frame_done (frame_done)
);

// File: tb/test_uart_rx_standby.sv
module test_uart_rx_standby;
    localparam int BITCLK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       ser = 1'b1;
    logic       one_wire = 1'b0;
    logic       nine_bit = 1'b0;
    logic       wake_sel = 1'b0;
    logic       sleep_set = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       rx_pin;
    logic       shared_pin;
    logic [8:0] rx_data;
    logic       data_ready;
    logic       idle_flag;
    logic       frame_err;
    logic       asleep;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Unselected pin is held low so any leakage would look like a start bit.
    assign rx_pin     = one_wire ? 1'b0 : ser;
    assign shared_pin = one_wire ? ser  : 1'b0;

    always #10 clk = ~clk;

    uart_rx_standby i_uart_rx_standby (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .rx_pin     (rx_pin),
        .shared_pin (shared_pin),
        .one_wire   (one_wire),
        .nine_bit   (nine_bit),
        .wake_sel   (wake_sel),
        .sleep_set  (sleep_set),
        .rd_strobe  (rd_strobe),
        .rx_data    (rx_data),
        .data_ready (data_ready),
        .idle_flag  (idle_flag),
        .frame_err  (frame_err),
        .asleep     (asleep)
    );

    function automatic logic [8:0] exp_word(input logic [8:0] d, input logic nb);
        return nb ? d : {1'b0, d[7:0]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk) sleep_set = 1'b1;
        @(negedge clk) sleep_set = 1'b0;
    endtask

    // One bit of BITCLK clocks; optional one-clock glitch at the 10th clock.
    task automatic send_bit(input logic b, input bit glitch, input bit slp);
        for (int c = 0; c < BITCLK; c++) begin
            @(negedge clk);
            ser       = (glitch && c == 9) ? ~b : b;
            sleep_set = slp && (c == 0);
        end
        sleep_set = 1'b0;
    endtask

    // Full frame; sleep_mid pulses sleep_set at data bit 1; chk_addr checks at
    // the start of the stop bit that standby has already ended (R9).
    task automatic send_frame(input logic [8:0] d, input logic nb, input logic stop,
                              input bit sleep_mid, input int glitch_bit, input bit chk_addr);
        int nbits = nb ? 9 : 8;
        send_bit(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < nbits; i++) begin
            send_bit(d[i], glitch_bit == i, sleep_mid && i == 1);
        end
        if (chk_addr) begin
            #1;
            chk("R9 asleep cleared before stop", {15'd0, asleep}, 16'd0);
            chk("R9 ready not yet set", {15'd0, data_ready}, 16'd0);
        end
        send_bit(stop, 1'b0, 1'b0);
        @(negedge clk) ser = 1'b1;
        idle_clocks(2);
    endtask

    initial begin
        logic [8:0] last;
        void'($urandom(32'd4021));
        // R1 reset state
        idle_clocks(5);
        chk("R1 rx_data", {7'd0, rx_data}, 16'd0);
        chk("R1 flags", {12'd0, data_ready, idle_flag, frame_err, asleep}, 16'd0);
        @(negedge clk) rst_n = 1'b1;

        // R8 idle flag after reset idle time, cleared by read
        idle_clocks(200);
        chk("R8 idle set", {15'd0, idle_flag}, 16'd1);
        pulse_read();
        idle_clocks(60);
        chk("R8 idle stays clear", {15'd0, idle_flag}, 16'd0);

        // R2 plain 8-bit frame
        send_frame(9'h05A, 1'b0, 1'b1, 0, -1, 0);
        chk("R2 data", {7'd0, rx_data}, 16'h005A);
        chk("R2 ready", {15'd0, data_ready}, 16'd1);
        pulse_read();
        chk("R2 read clears", {15'd0, data_ready}, 16'd0);

        // R2 majority filter against glitch
        send_frame(9'h03C, 1'b0, 1'b1, 0, 2, 0);
        chk("R2 glitch filtered", {7'd0, rx_data}, 16'h003C);
        pulse_read();

        // R3 nine-bit frame
        nine_bit = 1'b1;
        send_frame(9'h1A5, 1'b1, 1'b1, 0, -1, 0);
        chk("R3 nine-bit data", {7'd0, rx_data}, 16'h01A5);
        pulse_read();
        nine_bit = 1'b0;

        // R4 single-wire
        one_wire = 1'b1;
        idle_clocks(4);
        send_frame(9'h0C3, 1'b0, 1'b1, 0, -1, 0);
        chk("R4 shared pin data", {7'd0, rx_data}, 16'h00C3);
        chk("R4 ready", {15'd0, data_ready}, 16'd1);
        pulse_read();
        one_wire = 1'b0;
        idle_clocks(4);

        // R5 framing error
        send_frame(9'h077, 1'b0, 1'b0, 0, -1, 0);
        chk("R5 frame_err", {15'd0, frame_err}, 16'd1);
        chk("R5 data delivered", {7'd0, rx_data}, 16'h0077);
        pulse_read();
        chk("R5 read clears err", {15'd0, frame_err}, 16'd0);

        // R8 idle again after activity
        idle_clocks(200);
        chk("R8 idle after frame", {15'd0, idle_flag}, 16'd1);
        pulse_read();

        // R6/R7 standby entered mid-frame, idle-line wake
        wake_sel = 1'b0;
        send_frame(9'h011, 1'b0, 1'b1, 1, -1, 0);
        chk("R6 asleep", {15'd0, asleep}, 16'd1);
        chk("R6 ready suppressed", {15'd0, data_ready}, 16'd0);
        chk("R6 data held", {7'd0, rx_data}, 16'h0077);
        idle_clocks(100);
        chk("R7 not yet awake", {15'd0, asleep}, 16'd1);
        idle_clocks(120);
        chk("R7 woke on idle", {15'd0, asleep}, 16'd0);
        chk("R7 no idle flag", {15'd0, idle_flag}, 16'd0);
        chk("R7 no ready", {15'd0, data_ready}, 16'd0);

        // R10 sleep set on an already idle line
        pulse_sleep();
        idle_clocks(2);
        chk("R10 immediate wake", {15'd0, asleep}, 16'd0);
        chk("R10 idle flag untouched", {15'd0, idle_flag}, 16'd0);

        // R9 address-mark wake, 8-bit
        wake_sel = 1'b1;
        pulse_sleep();
        idle_clocks(250);
        chk("R9 idle does not wake", {15'd0, asleep}, 16'd1);
        send_frame(9'h035, 1'b0, 1'b1, 0, -1, 0);
        chk("R9 non-address ignored", {15'd0, data_ready}, 16'd0);
        chk("R9 still asleep", {15'd0, asleep}, 16'd1);
        send_frame(9'h035, 1'b0, 1'b0, 0, -1, 0);
        chk("R11 err suppressed asleep", {15'd0, frame_err}, 16'd0);
        chk("R6 data held in standby", {7'd0, rx_data}, 16'h0077);
        send_frame(9'h0A5, 1'b0, 1'b1, 0, -1, 1);
        chk("R9 address delivered", {7'd0, rx_data}, 16'h00A5);
        chk("R9 address ready", {15'd0, data_ready}, 16'd1);
        pulse_read();

        // R9 address-mark wake, 9-bit
        nine_bit = 1'b1;
        pulse_sleep();
        send_frame(9'h0FF, 1'b1, 1'b1, 0, -1, 0);
        chk("R9 bit7 not address in 9-bit", {15'd0, data_ready}, 16'd0);
        send_frame(9'h1C3, 1'b1, 1'b1, 0, -1, 1);
        chk("R9 9-bit address data", {7'd0, rx_data}, 16'h01C3);
        pulse_read();
        nine_bit = 1'b0;

        // R11 bad stop on waking address frame
        pulse_sleep();
        send_frame(9'h080, 1'b0, 1'b0, 0, -1, 0);
        chk("R11 err on address frame", {15'd0, frame_err}, 16'd1);
        chk("R11 data", {7'd0, rx_data}, 16'h0080);
        pulse_read();

        // Random frames while awake: R2, R3, R4
        wake_sel = 1'b0;
        last = 9'h080;
        for (int k = 0; k < 24; k++) begin
            logic [8:0] d;
            logic       nb;
            int         g;
            d  = 9'($urandom);
            nb = 1'($urandom);
            g  = ($urandom % 3 == 0) ? int'($urandom % 8) : -1;
            one_wire = 1'($urandom);
            nine_bit = nb;
            idle_clocks(3);
            send_frame(d, nb, 1'b1, 0, g, 0);
            chk(nb ? "R3 random" : (one_wire ? "R4 random" : "R2 random"),
                {7'd0, rx_data}, {7'd0, exp_word(d, nb)});
            chk("R2 random ready", {15'd0, data_ready}, 16'd1);
            pulse_read();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule